// File: doc/BRIEF.md
# I/O Privilege Check and Flag-Write Filter

This unit sits next to an instruction decoder and decides whether the current instruction may run at the current privilege level. The decoder supplies a small class code for the instruction and the current privilege level (CPL). The unit compares these against the I/O privilege level (IOPL) field of the flag word it holds. Two rules apply. I/O transfers, the interrupt-enable set and clear operations and the bus-lock prefix need CPL less than or equal to IOPL. System-table loads, the status-word load, the task-switch clear and halt need CPL equal to 0. When an instruction breaks its rule, the unit raises a one-cycle fault pulse and drops any flag write that came with it.

The unit also holds the 16-bit flag register and applies flag writes, for example from a flag pop or an interrupt return. It filters these writes rather than faulting them. The IOPL field changes only at CPL 0. The interrupt-enable bit changes only when CPL is at most the current IOPL. Every other bit takes the written value, and bit 1 always reads as 1. Masking a field never raises a fault.

Top module: `io_priv_flag_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, flags_o reads 16'h0002 and priv_fault_o reads 0.
- R2: The trusted classes are I/O = 3'd1, interrupt set/clear = 3'd2 and lock = 3'd3. A valid instruction in one of these classes raises priv_fault_o in the next cycle if and only if cpl_i > IOPL, where IOPL is flags bits 13:12.
- R3: The privileged class 3'd4 (table load, status-word load, task-switch clear, halt) raises priv_fault_o in the next cycle if and only if cpl_i != 0.
- R4: Class codes 3'd0 (ordinary), 3'd5 (flag restore), 3'd6 and 3'd7 never raise priv_fault_o. An invalid cycle never raises it either.
- R5: If an instruction faults, a flag write strobed with it has no effect.
- R6: On an accepted write, flag bits 13:12 (IOPL) take the written value only when cpl_i == 0. Otherwise they keep their old value, and no fault is raised.
- R7: On an accepted write, flag bit 9 (IF) takes the written value only when cpl_i <= the old IOPL. Otherwise it keeps its old value, and no fault is raised.
- R8: On an accepted write, all other flag bits take the written value, and bit 1 always reads 1.
- R9: A write is accepted only when instr_valid_i and flag_wr_i are both high. It appears on flags_o one cycle later. In any other cycle flags_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | A decoded instruction is present this cycle |
| instr_class_i | input | 3 | Instruction class code |
| cpl_i | input | 2 | Current privilege level |
| flag_wr_i | input | 1 | Flag write strobe that comes with the instruction |
| flag_wdata_i | input | 16 | Flag value to write, before filtering |
| priv_fault_o | output | 1 | One-cycle protection fault pulse |
| flags_o | output | 16 | Flag register |

## Verification
The class check is swept over every class code at every CPL with IOPL held at 1. This separates the IOPL-gated rule (the fault boundary falls between CPL 1 and 2) from the level-0 rule (the boundary falls between CPL 0 and 1) and from the classes that never fault. Flag writes are then issued at CPL 0, at CPL equal to IOPL and at CPL above IOPL. Each write flips IF, IOPL, bit 1 and unrelated bits at the same time, so the result shows which field each rule guards. A faulting I/O instruction that carries a write, a write strobe without a valid instruction, and a valid instruction without a write show that the register changes only on an accepted write.

// File: rtl/iopriv_pkg.sv
package iopriv_pkg;
    typedef enum logic [2:0] {
        CLS_PLAIN    = 3'd0,
        CLS_IO       = 3'd1,
        CLS_INTEN    = 3'd2,
        CLS_LOCK     = 3'd3,
        CLS_SYS      = 3'd4,
        CLS_FLAGLOAD = 3'd5
    } instr_class_e;

    localparam int unsigned CLASS_W = 3;
endpackage

// File: rtl/iopriv_rule_check.sv
module iopriv_rule_check
    import iopriv_pkg::*;
#(
    parameter int unsigned CPL_W = 2
) (
    input  logic [CLASS_W-1:0] cls_i,
    input  logic [CPL_W-1:0]   cpl_i,
    input  logic [CPL_W-1:0]   iopl_i,
    output logic               deny_o
);
    logic trusted_ok;
    logic level0;

    always_comb begin
        trusted_ok = (cpl_i <= iopl_i);
        level0     = (cpl_i == '0);
        case (instr_class_e'(cls_i))
            CLS_IO, CLS_INTEN, CLS_LOCK: deny_o = !trusted_ok;
            CLS_SYS:                     deny_o = !level0;
            default:                     deny_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/iopriv_flag_filter.sv
module iopriv_flag_filter #(
    parameter int unsigned FLAG_W    = 16,
    parameter int unsigned CPL_W     = 2,
    parameter int unsigned IOPL_LSB  = 12,
    parameter int unsigned IF_BIT    = 9,
    parameter int unsigned ONE_BIT   = 1
) (
    input  logic [FLAG_W-1:0] old_i,
    input  logic [FLAG_W-1:0] new_i,
    input  logic [CPL_W-1:0]  cpl_i,
    output logic [FLAG_W-1:0] merged_o
);
    logic [CPL_W-1:0] iopl_old;

    always_comb begin
        iopl_old = old_i[IOPL_LSB +: CPL_W];
        merged_o = new_i;
        if (cpl_i != '0) begin
            merged_o[IOPL_LSB +: CPL_W] = iopl_old;
        end
        if (cpl_i > iopl_old) begin
            merged_o[IF_BIT] = old_i[IF_BIT];
        end
        merged_o[ONE_BIT] = 1'b1;
    end
endmodule

// File: rtl/io_priv_flag_unit.sv
module io_priv_flag_unit
    import iopriv_pkg::*;
#(
    parameter int unsigned FLAG_W    = 16,
    parameter int unsigned CPL_W     = 2,
    parameter int unsigned IOPL_LSB  = 12,
    parameter int unsigned IF_BIT    = 9,
    parameter int unsigned ONE_BIT   = 1,
    parameter logic [15:0] RESET_VAL = 16'h0002
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                instr_valid_i,
    input  logic [CLASS_W-1:0]  instr_class_i,
    input  logic [CPL_W-1:0]    cpl_i,
    input  logic                flag_wr_i,
    input  logic [FLAG_W-1:0]   flag_wdata_i,
    output logic                priv_fault_o,
    output logic [FLAG_W-1:0]   flags_o
);
    localparam logic [FLAG_W-1:0] RST_FLAGS = FLAG_W'(RESET_VAL);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              fault;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic              deny;
    logic [FLAG_W-1:0] filtered;

    iopriv_rule_check #(.CPL_W(CPL_W)) u_rule (
        .cls_i  (instr_class_i),
        .cpl_i  (cpl_i),
        .iopl_i (st_q.flags[IOPL_LSB +: CPL_W]),
        .deny_o (deny)
    );

    iopriv_flag_filter #(
        .FLAG_W   (FLAG_W),
        .CPL_W    (CPL_W),
        .IOPL_LSB (IOPL_LSB),
        .IF_BIT   (IF_BIT),
        .ONE_BIT  (ONE_BIT)
    ) u_filter (
        .old_i    (st_q.flags),
        .new_i    (flag_wdata_i),
        .cpl_i    (cpl_i),
        .merged_o (filtered)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = instr_valid_i && deny;
        if (instr_valid_i && flag_wr_i && !deny) begin
            st_d.flags = filtered;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.flags <= RST_FLAGS;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign priv_fault_o = st_q.fault;
    assign flags_o      = st_q.flags;

    assert_bit1_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[ONE_BIT] == 1'b1);

    assert_fault_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        priv_fault_o |-> $past(instr_valid_i));

    assert_fault_blocks_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        priv_fault_o |-> (flags_o == $past(flags_o)));

    assert_iopl_level0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o[IOPL_LSB +: CPL_W] != $past(flags_o[IOPL_LSB +: CPL_W]))
            |-> ($past(cpl_i) == '0));

    assert_if_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o[IF_BIT] != $past(flags_o[IF_BIT]))
            |-> ($past(cpl_i) <= $past(flags_o[IOPL_LSB +: CPL_W])));

    assert_hold_without_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(instr_valid_i && flag_wr_i) |-> $stable(flags_o));
endmodule

// File: tb/sim_io_priv_flag_unit.sv
`timescale 1ns/1ps
module sim_io_priv_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  cls = 3'd0;
    logic [1:0]  cpl = 2'd0;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic        fault;
    logic [15:0] flags;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] m_flags = 16'h0002;

    logic [15:0] q_flags[$];
    logic        q_fault[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    io_priv_flag_unit u0 (
        .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid),
        .instr_class_i(cls), .cpl_i(cpl), .flag_wr_i(wr),
        .flag_wdata_i(wdata), .priv_fault_o(fault), .flags_o(flags)
    );

    task automatic step(input logic v, input logic [2:0] c, input logic [1:0] p,
                        input logic w, input logic [15:0] d, input string tag);
        logic [1:0]  iopl;
        logic        deny;
        logic [15:0] nf;
        @(negedge clk);
        valid = v; cls = c; cpl = p; wr = w; wdata = d;
        iopl = m_flags[13:12];
        deny = 1'b0;
        if (c == 3'd1 || c == 3'd2 || c == 3'd3) deny = (p > iopl);
        if (c == 3'd4) deny = (p != 2'd0);
        if (v && w && !deny) begin
            nf = d;
            if (p != 2'd0) nf[13:12] = m_flags[13:12];
            if (p > iopl)  nf[9] = m_flags[9];
            nf[1] = 1'b1;
            m_flags = nf;
        end
        q_flags.push_back(m_flags);
        q_fault.push_back(v && deny);
        q_tag.push_back(tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (q_flags.size() > 0) begin
            logic [15:0] ef;
            logic        eq;
            string       t;
            ef = q_flags.pop_front();
            eq = q_fault.pop_front();
            t  = q_tag.pop_front();
            n_checks++;
            if (flags !== ef || fault !== eq) begin
                n_fail++;
                $display("FAIL %s: flags=%h fault=%b expected flags=%h fault=%b",
                         t, flags, fault, ef, eq);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (flags !== 16'h0002 || fault !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: flags=%h fault=%b expected 0002 0", flags, fault);
        end
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        n_checks++;
        if (flags !== 16'h0002 || fault !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after reset: flags=%h fault=%b expected 0002 0", flags, fault);
        end
        // R6 R8: CPL 0 sets IOPL=1, IF=1, bit1 cleared in the data
        step(1, 3'd5, 2'd0, 1, 16'h1A41, "R6/R8 cpl0 write");
        // R2 R3 R4: sweep classes and CPL with IOPL=1
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 4; p++) begin
                string t;
                if (c >= 1 && c <= 3) t = "R2 trusted class";
                else if (c == 4)      t = "R3 privileged class";
                else                  t = "R4 never faults";
                step(1, 3'(c), 2'(p), 0, 16'hFFFF, t);
            end
        end
        // R6 R7 R8: CPL 2 above IOPL 1, both fields masked, others update
        step(1, 3'd5, 2'd2, 1, 16'h00C4, "R7/R6/R8 cpl above iopl");
        // R7 R6: CPL 1 equal to IOPL, IF may change, IOPL masked
        step(1, 3'd5, 2'd1, 1, 16'h3000, "R7/R6 cpl equal iopl");
        // R5: faulting I/O at CPL 3 carries a write
        step(1, 3'd1, 2'd3, 1, 16'hFFFF, "R5 faulting write dropped");
        // R5: faulting privileged op at CPL 1 carries a write
        step(1, 3'd4, 2'd1, 1, 16'h0000, "R5 privileged fault drops write");
        // R9: strobe without valid, valid without strobe
        step(0, 3'd5, 2'd0, 1, 16'h5555, "R9 strobe without valid");
        step(1, 3'd5, 2'd0, 0, 16'h5555, "R9 valid without strobe");
        // R6 R7 R8: CPL 0 clears IOPL and IF, bit1 still reads 1
        step(1, 3'd5, 2'd0, 1, 16'h0000, "R6/R7/R8 cpl0 clear");
        // R2: with IOPL 0, CPL 1 I/O faults, CPL 0 lock does not
        step(1, 3'd1, 2'd1, 0, 16'h0, "R2 iopl0 cpl1");
        step(1, 3'd3, 2'd0, 0, 16'h0, "R2 iopl0 cpl0");
        // R7: CPL 1 above IOPL 0 cannot set IF
        step(1, 3'd5, 2'd1, 1, 16'h0E00, "R7 iopl0 cpl1 masked");
        step(0, 3'd0, 2'd0, 0, 16'h0, "R9 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule